// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer that software controls through one 8-bit register. The register has a write strobe, write data, a read strobe and read data. Some byte values have a special meaning when written. One value turns the watchdog on and restarts its count. A pair of values written close together turns it off. Another value blocks that turn-off path until the next reset. Any other write whose top bit is clear sets a 3-bit interval field, and that field picks a timeout of a power-of-four number of clocks.

While the watchdog is enabled and nobody restarts it, the count runs up to the selected timeout. At that point the block raises a reset request for one clock and starts counting again. The system reset controller that acts on the request lies outside this block. The asynchronous active-low reset is synchronised inside the block before the control state uses it. After reset the watchdog is enabled, the count is zero and the interval field holds its largest value.

Top module: `wdk_top`

## Requirements
- R1: After reset the watchdog is enabled, `reset_req` is low, and a read returns 8'h07, which means the interval field resets to 3'b111.
- R2: Writing 8'hA5 enables the watchdog and restarts its count. `reset_req` is then first high in the clock that follows the T-th rising edge after the write edge, where T is the timeout.
- R3: The timeout T equals 4^(3 + F) clocks, where F is the interval field. F = 0 gives 64, F = 1 gives 256 and F = 2 gives 1024.
- R4: On expiry `reset_req` is high for exactly one clock and the count restarts. While the watchdog stays enabled and is not restarted, the next pulse follows T clocks later.
- R5: Writing 8'hDE and then 8'hAD disables the watchdog when the 8'hAD write edge comes 1 to 4 clocks after the 8'hDE write edge. While disabled, `reset_req` stays low.
- R6: A disable attempt is ignored if the 8'hAD write comes 5 or more clocks after 8'hDE, if any other write falls between the two, or if no 8'hDE came before it.
- R7: Writing 8'hFF blocks every later disable sequence until the next reset. The 8'hFF write does not enable the watchdog and does not restart its count.
- R8: A write with data bit 7 = 0 loads data bits [2:0] into the interval field. A write with bit 7 = 1 leaves the field unchanged.
- R9: When `rd_en` is high, `rd_data` is {5'b0, interval field} in the same cycle. When `rd_en` is low, `rd_data` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Register read data (combinational) |
| reset_req | output | 1 | One-clock reset request raised on watchdog expiry |

## Verification
The bench drives every input on the falling edge and samples on the falling edge. Each result can therefore be placed on an exact rising edge. Read data is combinational and is checked in the same cycle as `rd_en`. `reset_req` is registered, so after a restart write at edge E it is checked low after edge E+T-1, high after edge E+T and low after edge E+T+1, with a second pulse expected after edge E+2T. For the disable and lockout cases, `reset_req` pulses are counted over a 200-clock window with the interval field set to 0, so an enabled watchdog pulses at least three times in the window and a disabled one never pulses.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam logic [7:0] KEY_KICK = 8'hA5;
  localparam logic [7:0] KEY_ARM  = 8'hDE;
  localparam logic [7:0] KEY_FIRE = 8'hAD;
  localparam logic [7:0] KEY_LOCK = 8'hFF;
endpackage

// File: rtl/wdk_rst_sync.sv
module wdk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/wdk_arm.sv
module wdk_arm #(
  parameter int WIN_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       armed
);
  import wdk_pkg::*;
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  logic             armed_q, armed_d;
  logic [WIN_W-1:0] win_q, win_d;

  always_comb begin
    armed_d = armed_q;
    win_d   = win_q;
    if (wr_en) begin
      armed_d = (wr_data == KEY_ARM);
      win_d   = WIN_W'(WIN_CYC - 1);
    end else if (armed_q) begin
      if (win_q == '0) armed_d = 1'b0;
      else             win_d   = win_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      win_q   <= '0;
    end else begin
      armed_q <= armed_d;
      win_q   <= win_d;
    end
  end

  assign armed = armed_q;

  // R6
  armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data != KEY_ARM) |=> !armed_q);
endmodule

// File: rtl/wdk_ctrl.sv
module wdk_ctrl #(
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  input  logic               armed,
  output logic               enable,
  output logic               restart,
  output logic [FIELD_W-1:0] field
);
  import wdk_pkg::*;

  logic               en_q, en_d;
  logic               lock_q, lock_d;
  logic [FIELD_W-1:0] field_q, field_d;
  logic               kick, kill;

  assign kick = wr_en && (wr_data == KEY_KICK);
  assign kill = wr_en && (wr_data == KEY_FIRE) && armed && !lock_q;

  always_comb begin
    en_d    = en_q;
    lock_d  = lock_q;
    field_d = field_q;
    if (kick)      en_d = 1'b1;
    else if (kill) en_d = 1'b0;
    if (wr_en && (wr_data == KEY_LOCK)) lock_d = 1'b1;
    if (wr_en && !wr_data[7]) field_d = wr_data[FIELD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      lock_q  <= 1'b0;
      field_q <= '1;
    end else begin
      en_q    <= en_d;
      lock_q  <= lock_d;
      field_q <= field_d;
    end
  end

  assign enable  = en_q;
  assign restart = kick || kill;
  assign field   = field_q;

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && en_q) |=> en_q);
  // R7
  lock_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == KEY_LOCK && !en_q) |=> !en_q);
  // R8
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7]) |=> $stable(field_q));
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int FIELD_W  = 3,
  parameter int BASE_EXP = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               restart,
  input  logic [FIELD_W-1:0] field,
  output logic               reset_req
);
  localparam int MAX_EXP = 2 * (BASE_EXP + (1 << FIELD_W) - 1);
  localparam int CNT_W   = MAX_EXP;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic [CNT_W:0]   limit;
  logic             expire;

  assign limit  = (CNT_W + 1)'(1) << (2 * (BASE_EXP + int'(field)));
  assign expire = ({1'b0, cnt_q} >= (limit - 1'b1));

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (restart || !enable) begin
      cnt_d = '0;
    end else if (expire) begin
      cnt_d = '0;
      req_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign reset_req = req_q;

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  // R2
  kick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && !req_q));
  // R5
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !req_q);
endmodule

// File: rtl/wdk_top.sv
module wdk_top #(
  parameter int FIELD_W  = 3,
  parameter int BASE_EXP = 3,
  parameter int WIN_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       reset_req
);
  logic               rst_n_s;
  logic               armed, enable, restart;
  logic [FIELD_W-1:0] field;

  wdk_rst_sync u_sync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  wdk_arm #(.WIN_CYC(WIN_CYC)) u_arm (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_data(wr_data), .armed(armed)
  );

  wdk_ctrl #(.FIELD_W(FIELD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_data(wr_data),
    .armed(armed), .enable(enable), .restart(restart), .field(field)
  );

  wdk_counter #(.FIELD_W(FIELD_W), .BASE_EXP(BASE_EXP)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .enable(enable), .restart(restart),
    .field(field), .reset_req(reset_req)
  );

  assign rd_data = rd_en ? {{(8 - FIELD_W){1'b0}}, field} : 8'h00;

  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_en |-> (rd_data == 8'h00));
endmodule

// File: tb/wdk_top_tb_top.sv
module wdk_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       reset_req;

  int checks   = 0;
  int failures = 0;
  int pulses   = 0;

  always #5 clk = ~clk;

  wdk_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .reset_req(reset_req)
  );

  always @(negedge clk) if (reset_req) pulses <= pulses + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic rd_chk(input logic [7:0] exp, input string req);
    rd_en = 1'b1; #1;
    chk(rd_data == exp, req, rd_data, exp);
    rd_en = 1'b0; #1;
    chk(rd_data == 8'h00, "R9 idle read", rd_data, 0);
  endtask

  task automatic count_window(input int n, input bit want_pulses, input string req);
    int p0;
    p0 = pulses;
    step(n);
    if (want_pulses) chk(pulses - p0 >= 3, req, pulses - p0, 3);
    else             chk(pulses == p0, req, pulses - p0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(reset_req == 1'b0, "R1 req low", reset_req, 0);
    rd_chk(8'h07, "R1 field reset");
  endtask

  task automatic t_field();
    wr(8'h02); rd_chk(8'h02, "R8 load");
    wr(8'h85); rd_chk(8'h02, "R8 bit7 hold");
    wr(8'hA5); rd_chk(8'h02, "R8 key hold");
    wr(8'h7B); rd_chk(8'h03, "R8 low bits");
  endtask

  task automatic t_timing(input logic [7:0] fld, input int t);
    wr(fld);
    wr(8'hA5);
    step(t - 1); chk(reset_req == 1'b0, "R2 early", reset_req, 0);
    step(1);     chk(reset_req == 1'b1, "R3 expiry", reset_req, 1);
    step(1);     chk(reset_req == 1'b0, "R4 one clock", reset_req, 0);
    step(t - 1); chk(reset_req == 1'b1, "R4 repeat", reset_req, 1);
  endtask

  task automatic t_disable(input int gap, input bit works);
    do_reset();
    wr(8'h00); wr(8'hA5);
    wr(8'hDE); step(gap); wr(8'hAD);
    if (works) count_window(200, 1'b0, "R5 disabled");
    else       count_window(200, 1'b1, "R6 late fire");
  endtask

  task automatic t_intervene();
    do_reset();
    wr(8'h00); wr(8'hA5);
    wr(8'hDE); wr(8'h00); wr(8'hAD);
    count_window(200, 1'b1, "R6 intervening write");
    wr(8'hAD);
    count_window(200, 1'b1, "R6 fire without arm");
  endtask

  task automatic t_lock();
    do_reset();
    wr(8'h00); wr(8'hA5);
    step(20); wr(8'hFF);
    step(42); chk(reset_req == 1'b0, "R7 no restart early", reset_req, 0);
    step(1);  chk(reset_req == 1'b1, "R7 no restart", reset_req, 1);
    wr(8'hDE); wr(8'hAD);
    count_window(200, 1'b1, "R7 locked");
    do_reset();
    wr(8'h00);
    wr(8'hDE); wr(8'hAD);
    count_window(200, 1'b0, "R7 reset clears lock");
    wr(8'hFF);
    count_window(200, 1'b0, "R7 lock no enable");
    wr(8'hA5);
    step(63); chk(reset_req == 1'b0, "R2 reenable early", reset_req, 0);
    step(1);  chk(reset_req == 1'b1, "R2 reenable", reset_req, 1);
    wr(8'hDE); wr(8'hAD);
    count_window(200, 1'b1, "R7 locked after enable");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b0;
    @(negedge clk);
    t_reset();
    t_field();
    t_timing(8'h00, 64);
    t_timing(8'h01, 256);
    t_timing(8'h02, 1024);
    t_disable(0, 1'b1);
    t_disable(3, 1'b1);
    t_disable(4, 1'b0);
    t_intervene();
    t_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule